// File: doc/BRIEF.md
# Memory Error Capture Unit

This unit sits next to a memory controller and holds the details of the first failing memory access until software has dealt with it. The controller reports each error as a one-cycle strobe. The strobe carries the failing address, the error-class flags, the kind of requester and its ID, and the ECC syndrome and check bits. The unit latches these values into readable registers. It holds an interrupt line high while a capture is pending, and it drives a fatal line when the captured error cannot be recovered.

A second capture path handles CPU-side errors. It has its own status, its own interrupt and an address register that holds a word index. Software reads the captured values through a simple register port. It writes zero to a status register to release that capture.

Top module: `memerr_capture`

## Requirements
- R1: After reset, all status registers read zero and `memIrq`, `cpuIrq` and `memFatal` are low.
- R2: When memory status is zero, a `memErrValid` strobe loads the status and the address. The flag input bits are soft=0, hard=1, ecc=2, invalid=3. In the status word they appear as soft=bit21, hard=bit22, ecc=bit24 and invalid=bit25. The requester flag is set at bit 16 + source code, where the source codes are 0 cpu, 1 video input, 2 graphics back end, 3 rendering engine and 4 peripheral controller.
- R3: For a rendering-engine requester the requester ID is stored in status bits 15:8. For a peripheral requester it is stored in bits 7:0. For any other requester both fields stay zero.
- R4: A fresh capture with the ecc flag set loads the syndrome and check registers from the strobe. A fresh capture without it loads both registers with zero.
- R5: When status is non-zero, a further memory error sets only status bit 23 (multiple). The address, syndrome, check and all other status bits keep their values.
- R6: `memFatal` is high exactly when the status has the multiple bit (23) or the hard bit (22) set.
- R7: `memIrq` is high exactly while the memory status is non-zero.
- R8: A write of zero to memory status clears it, and `memIrq` is low in the next cycle. A non-zero write to a status register has no effect.
- R9: When an error strobe and the zero write to memory status fall in the same cycle, the unit makes a fresh capture: the new error is stored and the multiple bit stays clear.
- R10: The CPU path works the same way. A first `cpuErrValid` stores status bit0=1 and bits 2 and up = code, and stores the address as the byte address shifted right by 2. A later CPU error while the CPU status is non-zero sets only bit1. `cpuIrq` is high while the CPU status is non-zero, and a zero write to the CPU status clears it. The CPU path never affects `memFatal` or `memIrq`.
- R11: `regRdData` is combinational from `regAddr`. The register offsets are: 0 memory status, 1 memory address, 2 syndrome, 3 check bits, 4 CPU status, 5 CPU word address. Other offsets read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| memErrValid | input | 1 | Memory error strobe |
| memErrAddr | input | ADDR_W | Failing memory address |
| memErrFlags | input | 4 | Error class flags {invalid, ecc, hard, soft} |
| memErrSource | input | 3 | Requester kind code |
| memErrId | input | 8 | Requester ID |
| memErrSyndrome | input | SYN_W | ECC syndrome |
| memErrCheck | input | CHK_W | Generated check bits |
| cpuErrValid | input | 1 | CPU error strobe |
| cpuErrByteAddr | input | ADDR_W | Failing CPU byte address |
| cpuErrCode | input | CPU_CODE_W | CPU error code |
| regWrEn | input | 1 | Register write enable |
| regAddr | input | 3 | Register offset |
| regWrData | input | 32 | Register write data |
| regRdData | output | 32 | Register read data |
| memIrq | output | 1 | Memory error interrupt (level) |
| cpuIrq | output | 1 | CPU error interrupt (level) |
| memFatal | output | 1 | Unrecoverable memory error pending |

## Verification
The checks assume that every memory error strobe carries a source code from 0 to 4. With such a code the requester flag is set, so a capture always leaves the status non-zero. The checks also assume that a CPU strobe always sets the CPU capture bit. The stimulus uses only legal source codes and holds each strobe for exactly one cycle. It changes the register inputs half a cycle away from the sampling edge. Under these limits, any error strobe must raise its interrupt on the next cycle, and only a zero write can lower it.

// File: rtl/memerr_pkg.sv
package memerr_pkg;
  localparam int REG_W   = 32;
  localparam int ID_W    = 8;
  localparam int FLAG_W  = 4;
  localparam int SRC_W   = 3;
  localparam int RADDR_W = 3;
  localparam int NUM_SRC = 5;

  // incoming flag positions
  localparam int FL_SOFT = 0;
  localparam int FL_HARD = 1;
  localparam int FL_ECC  = 2;
  localparam int FL_INV  = 3;

  // memory status word layout
  localparam int ST_PERIPH_ID_LSB = 0;
  localparam int ST_RENDER_ID_LSB = 8;
  localparam int ST_SRC_LSB       = 16;
  localparam int ST_SOFT          = 21;
  localparam int ST_HARD          = 22;
  localparam int ST_MULTI         = 23;
  localparam int ST_ECC           = 24;
  localparam int ST_INV           = 25;

  // cpu status word layout
  localparam int CS_VALID    = 0;
  localparam int CS_MULTI    = 1;
  localparam int CS_CODE_LSB = 2;

  typedef enum logic [SRC_W-1:0] {
    SRC_CPU    = 3'd0,
    SRC_VIDEO  = 3'd1,
    SRC_GFX    = 3'd2,
    SRC_RENDER = 3'd3,
    SRC_PERIPH = 3'd4
  } reqSrc_e;

  typedef enum logic [RADDR_W-1:0] {
    RA_MSTAT = 3'd0,
    RA_MADDR = 3'd1,
    RA_SYN   = 3'd2,
    RA_CHK   = 3'd3,
    RA_CSTAT = 3'd4,
    RA_CADDR = 3'd5
  } regAddr_e;

  typedef struct packed {
    logic memLoad;
    logic memMulti;
    logic memClear;
    logic cpuLoad;
    logic cpuMulti;
    logic cpuClear;
  } ctlStrobes_t;
endpackage

// File: rtl/memerr_ctrl.sv
module memerr_ctrl
  import memerr_pkg::*;
(
  input  logic                 memErrValid,
  input  logic                 cpuErrValid,
  input  logic                 regWrEn,
  input  logic [RADDR_W-1:0]   regAddr,
  input  logic [REG_W-1:0]     regWrData,
  input  logic                 memBusy,
  input  logic                 cpuBusy,
  output ctlStrobes_t          strobes
);
  logic zeroWrite;
  logic memClrWr;
  logic cpuClrWr;

  assign zeroWrite = regWrEn && (regWrData == '0);
  assign memClrWr  = zeroWrite && (regAddr == RA_MSTAT);
  assign cpuClrWr  = zeroWrite && (regAddr == RA_CSTAT);

  // A clear in the same cycle as an error frees the slot for the new error (R9)
  always_comb begin
    strobes.memLoad  = memErrValid && (!memBusy || memClrWr);
    strobes.memMulti = memErrValid && memBusy && !memClrWr;
    strobes.memClear = memClrWr && !memErrValid;
    strobes.cpuLoad  = cpuErrValid && (!cpuBusy || cpuClrWr);
    strobes.cpuMulti = cpuErrValid && cpuBusy && !cpuClrWr;
    strobes.cpuClear = cpuClrWr && !cpuErrValid;
  end
endmodule

// File: rtl/memerr_dp.sv
module memerr_dp
  import memerr_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int SYN_W      = 8,
  parameter int CHK_W      = 8,
  parameter int CPU_CODE_W = 4
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  ctlStrobes_t           strobes,
  input  logic [ADDR_W-1:0]     memErrAddr,
  input  logic [FLAG_W-1:0]     memErrFlags,
  input  logic [SRC_W-1:0]      memErrSource,
  input  logic [ID_W-1:0]       memErrId,
  input  logic [SYN_W-1:0]      memErrSyndrome,
  input  logic [CHK_W-1:0]      memErrCheck,
  input  logic [ADDR_W-1:0]     cpuErrByteAddr,
  input  logic [CPU_CODE_W-1:0] cpuErrCode,
  input  logic [RADDR_W-1:0]    regAddr,
  output logic [REG_W-1:0]      regRdData,
  output logic                  memBusy,
  output logic                  cpuBusy,
  output logic                  memFatal
);
  localparam int CWADDR_W   = ADDR_W - 2;
  localparam int CPU_STAT_W = CS_CODE_LSB + CPU_CODE_W;

  logic [REG_W-1:0]      memStatQ;
  logic [ADDR_W-1:0]     memAddrQ;
  logic [SYN_W-1:0]      synQ;
  logic [CHK_W-1:0]      chkQ;
  logic [CPU_STAT_W-1:0] cpuStatQ;
  logic [CWADDR_W-1:0]   cpuAddrQ;

  logic [NUM_SRC-1:0]    srcHit;
  logic [REG_W-1:0]      newStat;
  logic [CPU_STAT_W-1:0] newCpuStat;

  for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
    assign srcHit[s] = (memErrSource == SRC_W'(s));
  end

  always_comb begin
    newStat = '0;
    newStat[ST_SOFT] = memErrFlags[FL_SOFT];
    newStat[ST_HARD] = memErrFlags[FL_HARD];
    newStat[ST_ECC]  = memErrFlags[FL_ECC];
    newStat[ST_INV]  = memErrFlags[FL_INV];
    newStat[ST_SRC_LSB +: NUM_SRC] = srcHit;
    if (srcHit[SRC_RENDER]) newStat[ST_RENDER_ID_LSB +: ID_W] = memErrId;
    if (srcHit[SRC_PERIPH]) newStat[ST_PERIPH_ID_LSB +: ID_W] = memErrId;
  end

  always_comb begin
    newCpuStat = '0;
    newCpuStat[CS_VALID] = 1'b1;
    newCpuStat[CS_CODE_LSB +: CPU_CODE_W] = cpuErrCode;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      memStatQ <= '0;
      memAddrQ <= '0;
      synQ     <= '0;
      chkQ     <= '0;
    end else if (strobes.memLoad) begin
      memStatQ <= newStat;
      memAddrQ <= memErrAddr;
      synQ     <= memErrFlags[FL_ECC] ? memErrSyndrome : '0;
      chkQ     <= memErrFlags[FL_ECC] ? memErrCheck    : '0;
    end else if (strobes.memMulti) begin
      memStatQ[ST_MULTI] <= 1'b1;
    end else if (strobes.memClear) begin
      memStatQ <= '0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cpuStatQ <= '0;
      cpuAddrQ <= '0;
    end else if (strobes.cpuLoad) begin
      cpuStatQ <= newCpuStat;
      cpuAddrQ <= cpuErrByteAddr[ADDR_W-1:2];
    end else if (strobes.cpuMulti) begin
      cpuStatQ[CS_MULTI] <= 1'b1;
    end else if (strobes.cpuClear) begin
      cpuStatQ <= '0;
    end
  end

  assign memBusy  = (memStatQ != '0);
  assign cpuBusy  = (cpuStatQ != '0);
  assign memFatal = memStatQ[ST_MULTI] | memStatQ[ST_HARD];

  always_comb begin
    case (regAddr)
      RA_MSTAT: regRdData = memStatQ;
      RA_MADDR: regRdData = REG_W'(memAddrQ);
      RA_SYN:   regRdData = REG_W'(synQ);
      RA_CHK:   regRdData = REG_W'(chkQ);
      RA_CSTAT: regRdData = REG_W'(cpuStatQ);
      RA_CADDR: regRdData = REG_W'(cpuAddrQ);
      default:  regRdData = '0;
    endcase
  end
endmodule

// File: rtl/memerr_capture.sv
module memerr_capture
  import memerr_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int SYN_W      = 8,
  parameter int CHK_W      = 8,
  parameter int CPU_CODE_W = 4
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  memErrValid,
  input  logic [ADDR_W-1:0]     memErrAddr,
  input  logic [3:0]            memErrFlags,
  input  logic [2:0]            memErrSource,
  input  logic [7:0]            memErrId,
  input  logic [SYN_W-1:0]      memErrSyndrome,
  input  logic [CHK_W-1:0]      memErrCheck,
  input  logic                  cpuErrValid,
  input  logic [ADDR_W-1:0]     cpuErrByteAddr,
  input  logic [CPU_CODE_W-1:0] cpuErrCode,
  input  logic                  regWrEn,
  input  logic [2:0]            regAddr,
  input  logic [31:0]           regWrData,
  output logic [31:0]           regRdData,
  output logic                  memIrq,
  output logic                  cpuIrq,
  output logic                  memFatal
);
  ctlStrobes_t strobes;
  logic memBusy;
  logic cpuBusy;

  memerr_ctrl u_ctrl (
    .memErrValid (memErrValid),
    .cpuErrValid (cpuErrValid),
    .regWrEn     (regWrEn),
    .regAddr     (regAddr),
    .regWrData   (regWrData),
    .memBusy     (memBusy),
    .cpuBusy     (cpuBusy),
    .strobes     (strobes)
  );

  memerr_dp #(
    .ADDR_W     (ADDR_W),
    .SYN_W      (SYN_W),
    .CHK_W      (CHK_W),
    .CPU_CODE_W (CPU_CODE_W)
  ) u_dp (
    .clk            (clk),
    .rstN           (rstN),
    .strobes        (strobes),
    .memErrAddr     (memErrAddr),
    .memErrFlags    (memErrFlags),
    .memErrSource   (memErrSource),
    .memErrId       (memErrId),
    .memErrSyndrome (memErrSyndrome),
    .memErrCheck    (memErrCheck),
    .cpuErrByteAddr (cpuErrByteAddr),
    .cpuErrCode     (cpuErrCode),
    .regAddr        (regAddr),
    .regRdData      (regRdData),
    .memBusy        (memBusy),
    .cpuBusy        (cpuBusy),
    .memFatal       (memFatal)
  );

  assign memIrq = memBusy;
  assign cpuIrq = cpuBusy;
endmodule

// File: rtl/memerr_capture_chk.sv
module memerr_capture_chk (
  input logic        clk,
  input logic        rstN,
  input logic        memErrValid,
  input logic        cpuErrValid,
  input logic        regWrEn,
  input logic [2:0]  regAddr,
  input logic [31:0] regWrData,
  input logic [31:0] regRdData,
  input logic        memIrq,
  input logic        cpuIrq,
  input logic        memFatal
);
  logic memClrWr;
  logic cpuClrWr;
  assign memClrWr = regWrEn && regAddr == 3'd0 && regWrData == 32'd0;
  assign cpuClrWr = regWrEn && regAddr == 3'd4 && regWrData == 32'd0;

  assert_fatal_R6: assert property (@(posedge clk) disable iff (!rstN)
    (regAddr == 3'd0) |-> (memFatal == (regRdData[23] | regRdData[22])));

  assert_irq_level_R7: assert property (@(posedge clk) disable iff (!rstN)
    (regAddr == 3'd0) |-> (memIrq == (regRdData != 32'd0)));

  assert_irq_sticky_R7: assert property (@(posedge clk) disable iff (!rstN)
    (memIrq && !memClrWr) |=> memIrq);

  assert_clear_R8: assert property (@(posedge clk) disable iff (!rstN)
    (memClrWr && !memErrValid) |=> !memIrq);

  assert_capture_R2: assert property (@(posedge clk) disable iff (!rstN)
    memErrValid |=> memIrq);

  assert_multi_R5: assert property (@(posedge clk) disable iff (!rstN)
    (memIrq && memErrValid && !memClrWr) |=> (memIrq && memFatal));

  assert_cpu_capture_R10: assert property (@(posedge clk) disable iff (!rstN)
    cpuErrValid |=> cpuIrq);

  assert_cpu_clear_R10: assert property (@(posedge clk) disable iff (!rstN)
    (cpuClrWr && !cpuErrValid) |=> !cpuIrq);
endmodule

bind memerr_capture memerr_capture_chk u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .memErrValid (memErrValid),
  .cpuErrValid (cpuErrValid),
  .regWrEn     (regWrEn),
  .regAddr     (regAddr),
  .regWrData   (regWrData),
  .regRdData   (regRdData),
  .memIrq      (memIrq),
  .cpuIrq      (cpuIrq),
  .memFatal    (memFatal)
);

// File: tb/memerr_capture_bench.sv
module memerr_capture_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        memErrValid = 1'b0;
  logic [31:0] memErrAddr = '0;
  logic [3:0]  memErrFlags = '0;
  logic [2:0]  memErrSource = '0;
  logic [7:0]  memErrId = '0;
  logic [7:0]  memErrSyndrome = '0;
  logic [7:0]  memErrCheck = '0;
  logic        cpuErrValid = 1'b0;
  logic [31:0] cpuErrByteAddr = '0;
  logic [3:0]  cpuErrCode = '0;
  logic        regWrEn = 1'b0;
  logic [2:0]  regAddr = '0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic        memIrq, cpuIrq, memFatal;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  always #5 clk = ~clk;

  memerr_capture u_memerr_capture (
    .clk(clk), .rstN(rstN),
    .memErrValid(memErrValid), .memErrAddr(memErrAddr), .memErrFlags(memErrFlags),
    .memErrSource(memErrSource), .memErrId(memErrId),
    .memErrSyndrome(memErrSyndrome), .memErrCheck(memErrCheck),
    .cpuErrValid(cpuErrValid), .cpuErrByteAddr(cpuErrByteAddr), .cpuErrCode(cpuErrCode),
    .regWrEn(regWrEn), .regAddr(regAddr), .regWrData(regWrData), .regRdData(regRdData),
    .memIrq(memIrq), .cpuIrq(cpuIrq), .memFatal(memFatal)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic readReg(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    regAddr = a;
    #1;
    d = regRdData;
  endtask

  task automatic writeReg(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0; regWrData = '0;
  endtask

  task automatic setMemErr(input logic [31:0] a, input logic [3:0] f, input logic [2:0] s,
                           input logic [7:0] id, input logic [7:0] syn, input logic [7:0] chk);
    memErrValid = 1'b1; memErrAddr = a; memErrFlags = f; memErrSource = s;
    memErrId = id; memErrSyndrome = syn; memErrCheck = chk;
  endtask

  task automatic memErr(input logic [31:0] a, input logic [3:0] f, input logic [2:0] s,
                        input logic [7:0] id, input logic [7:0] syn, input logic [7:0] chk);
    @(negedge clk);
    setMemErr(a, f, s, id, syn, chk);
    @(negedge clk);
    memErrValid = 1'b0;
  endtask

  task automatic cpuErr(input logic [31:0] a, input logic [3:0] code);
    @(negedge clk);
    cpuErrValid = 1'b1; cpuErrByteAddr = a; cpuErrCode = code;
    @(negedge clk);
    cpuErrValid = 1'b0;
  endtask

  task automatic testReset();
    logic [31:0] d;
    readReg(3'd0, d); check("R1 mem status", d, 32'h0);
    readReg(3'd4, d); check("R1 cpu status", d, 32'h0);
    check("R1 memIrq", {31'b0, memIrq}, 32'h0);
    check("R1 cpuIrq", {31'b0, cpuIrq}, 32'h0);
    check("R1 memFatal", {31'b0, memFatal}, 32'h0);
    readReg(3'd7, d); check("R11 unused offset", d, 32'h0);
  endtask

  // soft error from peripheral requester, then ignored non-zero write and clear
  task automatic testSoftPeriph();
    logic [31:0] d;
    memErr(32'h1234_5670, 4'b0001, 3'd4, 8'h5A, 8'hFF, 8'hEE);
    readReg(3'd0, d); check("R2 R3 periph status", d, 32'h0030_005A);
    readReg(3'd1, d); check("R2 address", d, 32'h1234_5670);
    readReg(3'd2, d); check("R4 syndrome zero on non-ecc", d, 32'h0);
    check("R7 memIrq high", {31'b0, memIrq}, 32'h1);
    check("R6 soft not fatal", {31'b0, memFatal}, 32'h0);
    writeReg(3'd0, 32'h0000_0001);
    readReg(3'd0, d); check("R8 nonzero write ignored", d, 32'h0030_005A);
    writeReg(3'd0, 32'h0);
    check("R8 memIrq low after clear", {31'b0, memIrq}, 32'h0);
    readReg(3'd0, d); check("R8 status cleared", d, 32'h0);
  endtask

  // ECC error from rendering engine, then a second error
  task automatic testEccRenderMulti();
    logic [31:0] d;
    memErr(32'h0000_8000, 4'b0100, 3'd3, 8'h33, 8'hA5, 8'h3C);
    readReg(3'd0, d); check("R2 R3 render status", d, 32'h0108_3300);
    readReg(3'd2, d); check("R4 syndrome", d, 32'h0000_00A5);
    readReg(3'd3, d); check("R4 check bits", d, 32'h0000_003C);
    check("R6 ecc not fatal", {31'b0, memFatal}, 32'h0);
    memErr(32'hDEAD_0000, 4'b0010, 3'd0, 8'h11, 8'h01, 8'h02);
    readReg(3'd0, d); check("R5 multiple only", d, 32'h0188_3300);
    readReg(3'd1, d); check("R5 address kept", d, 32'h0000_8000);
    readReg(3'd2, d); check("R5 syndrome kept", d, 32'h0000_00A5);
    check("R6 multiple fatal", {31'b0, memFatal}, 32'h1);
    writeReg(3'd0, 32'h0);
    check("R6 fatal drops on clear", {31'b0, memFatal}, 32'h0);
  endtask

  task automatic testHardGfx();
    logic [31:0] d;
    memErr(32'h0000_0040, 4'b0010, 3'd2, 8'h77, 8'h0, 8'h0);
    readReg(3'd0, d); check("R3 no id for gfx", d, 32'h0044_0000);
    check("R6 hard fatal", {31'b0, memFatal}, 32'h1);
  endtask

  // error in the same cycle as the clearing write
  task automatic testClearRace();
    logic [31:0] d;
    @(negedge clk);
    regWrEn = 1'b1; regAddr = 3'd0; regWrData = 32'h0;
    setMemErr(32'h0000_0ABC, 4'b1000, 3'd1, 8'h99, 8'h0, 8'h0);
    @(negedge clk);
    regWrEn = 1'b0; memErrValid = 1'b0;
    readReg(3'd0, d); check("R9 fresh capture", d, 32'h0202_0000);
    readReg(3'd1, d); check("R9 new address", d, 32'h0000_0ABC);
    check("R9 not fatal", {31'b0, memFatal}, 32'h0);
  endtask

  task automatic testCpu();
    logic [31:0] d;
    cpuErr(32'h0000_1F0C, 4'd3);
    readReg(3'd4, d); check("R10 cpu status", d, 32'h0000_000D);
    readReg(3'd5, d); check("R10 word address", d, 32'h0000_07C3);
    check("R10 cpuIrq", {31'b0, cpuIrq}, 32'h1);
    cpuErr(32'h0000_F000, 4'd9);
    readReg(3'd4, d); check("R10 cpu multiple", d, 32'h0000_000F);
    readReg(3'd5, d); check("R10 cpu address kept", d, 32'h0000_07C3);
    check("R10 fatal unaffected", {31'b0, memFatal}, 32'h0);
    writeReg(3'd4, 32'h0);
    check("R10 cpuIrq cleared", {31'b0, cpuIrq}, 32'h0);
    check("R10 memIrq unaffected", {31'b0, memIrq}, 32'h1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    testReset();
    testSoftPeriph();
    testEccRenderMulti();
    testHardGfx();
    testClearRace();
    testCpu();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        nChecks++;
        nFails++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end
endmodule